// File: doc/BRIEF.md
# GPIO Bank Interrupt Sensing Unit

This unit watches one bank of 32 general-purpose input pins and turns level changes or held levels into latched pending flags. Each pin has its own arm bit, and three sense bits (polarity, level-mode and any-edge) that together choose a mode: rising edge, falling edge, both edges, active-high level or active-low level. An armed pin whose chosen condition is met raises its pending flag. The armed pending flags are ORed into one interrupt line for the processor.

Software reaches the unit through a small word-wide register port. Writes take effect on the clock edge where the write strobe is high, and reads come back combinationally. A pending flag is cleared by writing a one to its bit. Pin levels arrive already synchronized to the unit clock. Edges are found by comparing each pin with its own value one cycle earlier.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset the arm, polarity, level-mode, any-edge and pending registers all read zero and `irqOut` is low.
- R2: The register map uses the byte address. Arm is at 0x00, polarity at 0x04, level-mode at 0x08, any-edge at 0x0C and pending at 0x10. Pin n uses bit n of each register. The first four registers read back what was last written to them. Any other address reads zero, and a write there changes no register.
- R3: A pin with level-mode 0, any-edge 0 and polarity 1 sets its pending bit on a 0-to-1 change of its level, one clock after the change is sampled. A 1-to-0 change and a steady level do not set it.
- R4: A pin with level-mode 0, any-edge 0 and polarity 0 sets its pending bit on a 1-to-0 change only.
- R5: A pin with level-mode 0 and any-edge 1 sets its pending bit on either change, whatever its polarity bit holds.
- R6: A pin with level-mode 1 sets its pending bit in every cycle its level equals its polarity bit (1 = active high, 0 = active low). Its any-edge bit is ignored. A cleared bit comes back on the next edge while the active level holds.
- R7: A pin whose arm bit is 0 never sets its pending bit, whatever its level does.
- R8: A write to the pending register clears each bit written as 1. Bits written as 0 keep their value.
- R9: If a pin's event and a clear of its pending bit fall in the same cycle, the bit ends set.
- R10: `irqOut` is high exactly when some pin has both its pending bit and its arm bit set. Clearing an arm bit masks that pin's pending bit from `irqOut` but does not clear it.
- R11: A write to the pending register never sets a pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (5) | Byte address of the register |
| regWdata | input | DATA_W (32) | Write data |
| regRdata | output | DATA_W (32) | Combinational read data for `regAddr` |
| pinLevel | input | NUM_PINS (32) | Synchronized pin levels |
| irqOut | output | 1 | Combined interrupt request |

## Verification
If the stored previous level of a pin is wrong, an edge is either missed or duplicated. This shows in the pending readback and on `irqOut` on the edge after the pin change. A mode decoded wrongly gives the wrong pending value for at least one pairing of mode and transition, so the bench sweeps all eight sense codes against all four before/after pin pairings, with the arm bit both on and off. Mistakes in the clear path show either as a bit that survives a clear of a quiet pin, or as an event that is lost when it lands in the same cycle as a clear. Both are visible in the readback taken one cycle later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // byte offsets of the bank registers
  localparam int OFS_ARM   = 'h00;
  localparam int OFS_POL   = 'h04;
  localparam int OFS_LVL   = 'h08;
  localparam int OFS_ANY   = 'h0C;
  localparam int OFS_PEND  = 'h10;

  // write strobes from the decoder to the sense core
  typedef struct packed {
    logic wrArm;
    logic wrPol;
    logic wrLvl;
    logic wrAny;
    logic wrClear;
  } regStrobeT;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ARM,
    RD_POL,
    RD_LVL,
    RD_ANY,
    RD_PEND
  } rdSelT;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobeT         strobe,
  output rdSelT             rdSel
);

  always_comb begin
    rdSel = RD_NONE;
    if (regAddr == ADDR_W'(OFS_ARM))       rdSel = RD_ARM;
    else if (regAddr == ADDR_W'(OFS_POL))  rdSel = RD_POL;
    else if (regAddr == ADDR_W'(OFS_LVL))  rdSel = RD_LVL;
    else if (regAddr == ADDR_W'(OFS_ANY))  rdSel = RD_ANY;
    else if (regAddr == ADDR_W'(OFS_PEND)) rdSel = RD_PEND;
  end

  always_comb begin
    strobe         = '0;
    strobe.wrArm   = regWe && (rdSel == RD_ARM);
    strobe.wrPol   = regWe && (rdSel == RD_POL);
    strobe.wrLvl   = regWe && (rdSel == RD_LVL);
    strobe.wrAny   = regWe && (rdSel == RD_ANY);
    strobe.wrClear = regWe && (rdSel == RD_PEND);
  end

endmodule

// File: rtl/irq_pin_sense.sv
module irq_pin_sense (
  input  logic levelNow,
  input  logic levelPrev,
  input  logic armBit,
  input  logic polBit,
  input  logic lvlBit,
  input  logic anyBit,
  output logic hit
);

  logic rise;
  logic fall;
  logic edgeHit;
  logic levelHit;

  always_comb begin
    rise     = levelNow & ~levelPrev;
    fall     = ~levelNow & levelPrev;
    if (anyBit)      edgeHit = rise | fall;
    else if (polBit) edgeHit = rise;
    else             edgeHit = fall;
    levelHit = (levelNow == polBit);
    hit      = armBit & (lvlBit ? levelHit : edgeHit);
  end

endmodule

// File: rtl/irq_sense_core.sv
module irq_sense_core
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobeT           strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinLevel,
  output logic [NUM_PINS-1:0] armQ,
  output logic [NUM_PINS-1:0] polQ,
  output logic [NUM_PINS-1:0] lvlQ,
  output logic [NUM_PINS-1:0] anyQ,
  output logic [NUM_PINS-1:0] pendQ
);

  logic [NUM_PINS-1:0] prevQ;
  logic [NUM_PINS-1:0] hitVec;
  logic [NUM_PINS-1:0] clrMask;
  logic [NUM_PINS-1:0] pendNext;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_pin_sense u_sense (
      .levelNow (pinLevel[p]),
      .levelPrev(prevQ[p]),
      .armBit   (armQ[p]),
      .polBit   (polQ[p]),
      .lvlBit   (lvlQ[p]),
      .anyBit   (anyQ[p]),
      .hit      (hitVec[p])
    );
  end

  // a new event beats a clear of the same bit
  always_comb begin
    clrMask  = strobe.wrClear ? wrData : '0;
    pendNext = (pendQ & ~clrMask) | hitVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ  <= '0;
      polQ  <= '0;
      lvlQ  <= '0;
      anyQ  <= '0;
      pendQ <= '0;
      prevQ <= '0;
    end else begin
      if (strobe.wrArm) armQ <= wrData;
      if (strobe.wrPol) polQ <= wrData;
      if (strobe.wrLvl) lvlQ <= wrData;
      if (strobe.wrAny) anyQ <= wrData;
      pendQ <= pendNext;
      prevQ <= pinLevel;
    end
  end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] pinLevel,
  output logic                irqOut
);

  regStrobeT           strobe;
  rdSelT               rdSel;
  logic [NUM_PINS-1:0] armW;
  logic [NUM_PINS-1:0] polW;
  logic [NUM_PINS-1:0] lvlW;
  logic [NUM_PINS-1:0] anyW;
  logic [NUM_PINS-1:0] pendW;

  irq_reg_decode #(.ADDR_W(ADDR_W)) u_ctrl (
    .regWe  (regWe),
    .regAddr(regAddr),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  irq_sense_core #(.NUM_PINS(NUM_PINS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .wrData  (regWdata[NUM_PINS-1:0]),
    .pinLevel(pinLevel),
    .armQ    (armW),
    .polQ    (polW),
    .lvlQ    (lvlW),
    .anyQ    (anyW),
    .pendQ   (pendW)
  );

  always_comb begin
    case (rdSel)
      RD_ARM:  regRdata = DATA_W'(armW);
      RD_POL:  regRdata = DATA_W'(polW);
      RD_LVL:  regRdata = DATA_W'(lvlW);
      RD_ANY:  regRdata = DATA_W'(anyW);
      RD_PEND: regRdata = DATA_W'(pendW);
      default: regRdata = '0;
    endcase
  end

  assign irqOut = |(pendW & armW);

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic [NUM_PINS-1:0] pinLevel,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] armW,
  input logic [NUM_PINS-1:0] polW,
  input logic [NUM_PINS-1:0] lvlW,
  input logic [NUM_PINS-1:0] anyW,
  input logic [NUM_PINS-1:0] pendW
);

  logic [NUM_PINS-1:0] seenQ;
  logic [NUM_PINS-1:0] upV;
  logic [NUM_PINS-1:0] downV;
  logic [NUM_PINS-1:0] expHit;
  logic [NUM_PINS-1:0] clrV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenQ <= '0;
    else       seenQ <= pinLevel;
  end

  always_comb begin
    upV    = pinLevel & ~seenQ;
    downV  = ~pinLevel & seenQ;
    expHit = armW & ((lvlW & ~(pinLevel ^ polW)) |
                     (~lvlW & anyW & (upV | downV)) |
                     (~lvlW & ~anyW & polW & upV) |
                     (~lvlW & ~anyW & ~polW & downV));
    clrV   = (regWe && regAddr == ADDR_W'(16)) ? regWdata[NUM_PINS-1:0] : '0;
  end

  // R3 R4 R5 R6 R9
  event_sets_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (expHit != '0) |=> ((pendW & $past(expHit)) == $past(expHit)));

  // R7 R11
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendW & ~$past(pendW) & ~$past(expHit)) == '0));

  // R8
  pend_drop_needs_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((~pendW & $past(pendW) & ~$past(clrV)) == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armW == '0) |-> !irqOut);

  // R10
  irq_has_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((pendW & armW) != '0));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(
  .NUM_PINS(NUM_PINS),
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .pinLevel(pinLevel),
  .irqOut  (irqOut),
  .armW    (armW),
  .polW    (polW),
  .lvlW    (lvlW),
  .anyW    (anyW),
  .pendW   (pendW)
);

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

  localparam int A_ARM = 'h00, A_POL = 'h04, A_LVL = 'h08, A_ANY = 'h0C, A_PEND = 'h10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [31:0] pinLevel = '0;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  gpio_irq_bank i_gpio_irq_bank (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pinLevel(pinLevel), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    regWe = 1'b1; regAddr = 5'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    regAddr = 5'(a);
    #1;
    d = regRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cleanSlate();
    wr(A_ARM, '0); wr(A_POL, '0); wr(A_LVL, '0); wr(A_ANY, '0);
    pinLevel = '0;
    idle(2);
    wr(A_PEND, '1);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] bitP;
    logic        expBit;
    int          idx;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_ARM, v);  chk("R1 arm", v, '0);
    rd(A_POL, v);  chk("R1 pol", v, '0);
    rd(A_LVL, v);  chk("R1 lvl", v, '0);
    rd(A_ANY, v);  chk("R1 any", v, '0);
    rd(A_PEND, v); chk("R1 pend", v, '0);
    chk("R1 irq", 32'(irqOut), 0);

    // R2 readback and unmapped addresses
    wr(A_POL, 32'h1234_5678); wr(A_LVL, 32'h0F0F_00FF); wr(A_ANY, 32'hDEAD_BEEF);
    wr(A_ARM, 32'hA5A5_5A5A);
    rd(A_POL, v); chk("R2 pol", v, 32'h1234_5678);
    rd(A_LVL, v); chk("R2 lvl", v, 32'h0F0F_00FF);
    rd(A_ANY, v); chk("R2 any", v, 32'hDEAD_BEEF);
    rd(A_ARM, v); chk("R2 arm", v, 32'hA5A5_5A5A);
    wr('h14, '1); wr('h02, '1); wr('h1C, '1);
    rd('h14, v);  chk("R2 unmapped read", v, '0);
    rd(A_ARM, v); chk("R2 arm after stray writes", v, 32'hA5A5_5A5A);
    rd(A_POL, v); chk("R2 pol after stray writes", v, 32'h1234_5678);
    cleanSlate();

    // R3 R4 R5 R6 R7 sweep: sense code x before/after level x arm
    idx = 0;
    for (int m = 0; m < 8; m++) begin
      for (int f = 0; f < 2; f++) begin
        for (int t = 0; t < 2; t++) begin
          for (int e = 0; e < 2; e++) begin
            automatic int p = (idx * 7) % 32;
            idx++;
            bitP = 32'(1) << p;
            cleanSlate();
            pinLevel[p] = f[0];
            wr(A_POL, m[0] ? bitP : '0);
            wr(A_LVL, m[1] ? bitP : '0);
            wr(A_ANY, m[2] ? bitP : '0);
            wr(A_ARM, e[0] ? bitP : '0);
            idle(2);
            wr(A_PEND, '1);
            pinLevel[p] = t[0];
            @(negedge clk);
            if (e == 0) expBit = 1'b0;
            else if (m[1]) expBit = (f[0] == m[0]) || (t[0] == m[0]);
            else if (m[2]) expBit = (f != t);
            else if (m[0]) expBit = (f == 0) && (t == 1);
            else expBit = (f == 1) && (t == 0);
            rd(A_PEND, v);
            chk($sformatf("R3/R4/R5/R6/R7 pend code=%0d %0d->%0d arm=%0d", m, f, t, e),
                v, expBit ? bitP : '0);
            chk($sformatf("R10 irq code=%0d %0d->%0d arm=%0d", m, f, t, e),
                32'(irqOut), 32'(expBit));
          end
        end
      end
    end

    // R8 partial clear
    cleanSlate();
    wr(A_POL, 32'hF); wr(A_ARM, 32'hF);
    pinLevel[3:0] = 4'hF;
    @(negedge clk);
    rd(A_PEND, v); chk("R8 four rising edges", v, 32'hF);
    wr(A_PEND, 32'h5);
    rd(A_PEND, v); chk("R8 clear ones only", v, 32'hA);
    wr(A_PEND, 32'h0);
    rd(A_PEND, v); chk("R8 zero write keeps", v, 32'hA);

    // R10 masking by arm without clearing
    chk("R10 irq armed", 32'(irqOut), 1);
    wr(A_ARM, 32'h0);
    chk("R10 irq masked", 32'(irqOut), 0);
    rd(A_PEND, v); chk("R10 pend kept while masked", v, 32'hA);
    wr(A_ARM, 32'h2);
    chk("R10 irq re-armed", 32'(irqOut), 1);

    // R9 edge in the same cycle as its clear
    cleanSlate();
    wr(A_POL, 32'h10); wr(A_ARM, 32'h10);
    idle(1);
    regWe = 1'b1; regAddr = 5'(A_PEND); regWdata = 32'h10; pinLevel[4] = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
    rd(A_PEND, v); chk("R9 event beats clear", v, 32'h10);

    // R6 level re-sets after clear while active
    cleanSlate();
    wr(A_LVL, 32'h100); wr(A_ARM, 32'h100);
    pinLevel[8] = 1'b0;
    idle(1);
    wr(A_PEND, 32'h100);
    rd(A_PEND, v); chk("R6 active-low level back after clear", v, 32'h100);

    // R11 clear write never sets
    cleanSlate();
    wr(A_POL, '1); wr(A_ARM, '1);
    idle(1);
    wr(A_PEND, '1);
    rd(A_PEND, v); chk("R11 write ones to empty pend", v, '0);
    chk("R11 irq stays low", 32'(irqOut), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule